// File: doc/BRIEF.md
# Chained Software-Increment Counter Bank

This block holds a small bank of 32-bit event counters and a separate cycle-count register. Software raises a counter by one through a single-cycle increment strobe that carries a 32-bit select mask. An increment lands on a counter only when four things hold: the bank's global run bit is set, the counter's enable bit is set, the counter's bit is present in the mask, and the counter's event-type field holds the software-increment code. Any counter that wraps from all-ones to zero records the wrap in a sticky overflow status register.

Counters are grouped in even/odd pairs. When the odd member of a pair is programmed with the chain event code, the pair acts as one 64-bit counter. A wrap of the even (low) half then carries one into the odd (high) half instead of flagging an overflow on the low half. A wrap of the high half caused by that carry flags an overflow on the high index. The carry reaches the high half even when the high half's own enable bit is clear.

A register port reads and writes every counter, the event types, the global run bit, the enables (set and clear views) and the overflow status (write-one-to-clear). Every effect of one increment strobe is applied on one clock edge and can be read back in the cycle after it.

Top module: `swinc_counter_bank`

## Requirements
- R1: When the global run bit (bit 0 at address 0x00) is clear, an increment strobe changes no counter and no overflow bit.
- R2: An increment strobe whose mask has no bit set changes no counter and no overflow bit.
- R3: A counter whose enable bit is clear is not incremented by a strobe that selects it. The enable register is written as set-bits at 0x01 and clear-bits at 0x02, and both addresses read it back. Bit i enables counter i and bit 31 enables the cycle counter.
- R4: A selected, enabled counter is incremented only when its event-type field (low 10 bits at 0x40+i) equals the software-increment code 0x000. Any other code leaves it unchanged.
- R5: The cycle-count register (address 0x3F, mask and enable bit 31) never changes in response to an increment strobe.
- R6: Event counters (address 0x20+i, i = 0..5) are 32 bits wide and wrap from 0xFFFFFFFF to 0.
- R7: When an unchained counter wraps through an increment, its bit i in the overflow status register (address 0x03) is set.
- R8: A pair (2k, 2k+1) is chained when counter 2k+1 has event code 0x01E. When chained counter 2k wraps, counter 2k+1 increases by one and overflow bit 2k is not set.
- R9: When that carry wraps counter 2k+1 to zero, overflow bit 2k+1 is set.
- R10: The carry into a chained high counter is applied even if the high counter's enable bit is clear.
- R11: Overflow bits are sticky. Writing a one to a bit at address 0x03 clears it. If a wrap sets the same bit in the same cycle, the set wins.
- R12: After reset, the run bit, enables, counters, event types, cycle counter and overflow status all read zero. Each register written through the port reads back the written value.
- R13: All counter and status updates from one strobe are applied on one clock edge and are visible on the read port in the next cycle. A register write to a counter in the same cycle as a strobe takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swinc_we_i | input | 1 | Increment strobe, one cycle |
| swinc_mask_i | input | 32 | Counter select mask carried by the strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |

## Verification
A wrong gating term (run bit, enable, event code or the cycle-counter exclusion) leaves a counter off by one. That error shows on the read port in the cycle right after the strobe. A faulty chain decision appears either as a high counter that did not advance or as an overflow bit set on the wrong index of the pair, and it becomes visible only on the strobe that wraps the low half. The sweeps therefore preload counters close to all-ones, so that wraps happen within a few dozen strobes. A lost sticky bit or a wrong set-versus-clear priority shows in the overflow register on the next read after a write-one-to-clear.

// File: rtl/swinc_bank_pkg.sv
package swinc_bank_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int EVT_W   = 10;
  localparam int CYC_IDX = 31;

  localparam logic [EVT_W-1:0] EVT_SWINC = 10'h000;
  localparam logic [EVT_W-1:0] EVT_CHAIN = 10'h01E;

  localparam logic [ADDR_W-1:0] A_CTRL     = 7'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 7'h01;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 7'h02;
  localparam logic [ADDR_W-1:0] A_OVF      = 7'h03;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_CYC      = 7'h3F;
  localparam logic [ADDR_W-1:0] A_EVT_BASE = 7'h40;
endpackage

// File: rtl/swinc_select.sv
module swinc_select
  import swinc_bank_pkg::*;
#(
  parameter int NUM_CNT = 6
) (
  input  logic                     fire_i,
  input  logic [NUM_CNT-1:0]       mask_i,
  input  logic [NUM_CNT-1:0]       en_i,
  input  logic [NUM_CNT*EVT_W-1:0] evt_i,
  output logic [NUM_CNT-1:0]       hit_o,
  output logic [NUM_CNT-1:0]       chain_o
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
    logic [EVT_W-1:0] evt;
    assign evt      = evt_i[i*EVT_W +: EVT_W];
    assign hit_o[i] = fire_i & mask_i[i] & en_i[i] & (evt == EVT_SWINC);
    // chain flag sits on the low (even) index, decoded from the odd partner
    if ((i % 2 == 0) && (i + 1 < NUM_CNT)) begin : g_even
      assign chain_o[i] = (evt_i[(i+1)*EVT_W +: EVT_W] == EVT_CHAIN);
    end else begin : g_odd
      assign chain_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/swinc_pair.sv
module swinc_pair #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic             hit_lo_i,
  input  logic             hit_hi_i,
  input  logic             chain_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic             ovf_lo_o,
  output logic             ovf_hi_o
);
  logic lo_wrap;
  logic hi_step;

  assign lo_wrap = hit_lo_i & (&lo_i);
  assign lo_o    = lo_i + CNT_W'(hit_lo_i);

  // chained: high half advances on low wrap only, regardless of its own gating
  assign hi_step  = chain_i ? lo_wrap : hit_hi_i;
  assign hi_o     = hi_i + CNT_W'(hi_step);
  assign ovf_lo_o = lo_wrap & ~chain_i;
  assign ovf_hi_o = hi_step & (&hi_i);
endmodule

// File: rtl/swinc_counter_bank.sv
module swinc_counter_bank
  import swinc_bank_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int CNT_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swinc_we_i,
  input  logic [DATA_W-1:0] swinc_mask_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int NUM_CNT = 2 * NUM_PAIRS;

  logic                     ctrl_en_q;
  logic [NUM_CNT-1:0]       en_q;
  logic                     cyc_en_q;
  logic [NUM_CNT-1:0]       ovf_q;
  logic [CNT_W-1:0]         cyc_q;
  logic [CNT_W-1:0]         cnt_q   [NUM_CNT];
  logic [EVT_W-1:0]         evt_q   [NUM_CNT];
  logic [CNT_W-1:0]         cnt_nxt [NUM_CNT];
  logic [NUM_CNT*EVT_W-1:0] evt_flat;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       hit;
  logic [NUM_CNT-1:0]       chain;
  logic [NUM_CNT-1:0]       ovf_set;
  logic                     fire;
  logic                     unused_mask;

  assign unused_mask = ^swinc_mask_i[DATA_W-1:NUM_CNT];
  assign fire        = swinc_we_i & ctrl_en_q;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_flat
    assign evt_flat[i*EVT_W +: EVT_W] = evt_q[i];
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
  end

  swinc_select #(.NUM_CNT(NUM_CNT)) u_select (
    .fire_i  (fire),
    .mask_i  (swinc_mask_i[NUM_CNT-1:0]),
    .en_i    (en_q),
    .evt_i   (evt_flat),
    .hit_o   (hit),
    .chain_o (chain)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    swinc_pair #(.CNT_W(CNT_W)) u_pair (
      .lo_i     (cnt_q[2*p]),
      .hi_i     (cnt_q[2*p+1]),
      .hit_lo_i (hit[2*p]),
      .hit_hi_i (hit[2*p+1]),
      .chain_i  (chain[2*p]),
      .lo_o     (cnt_nxt[2*p]),
      .hi_o     (cnt_nxt[2*p+1]),
      .ovf_lo_o (ovf_set[2*p]),
      .ovf_hi_o (ovf_set[2*p+1])
    );
  end

  logic wr_ctrl, wr_en_set, wr_en_clr, wr_ovf, wr_cyc;
  assign wr_ctrl   = reg_we_i & (reg_addr_i == A_CTRL);
  assign wr_en_set = reg_we_i & (reg_addr_i == A_EN_SET);
  assign wr_en_clr = reg_we_i & (reg_addr_i == A_EN_CLR);
  assign wr_ovf    = reg_we_i & (reg_addr_i == A_OVF);
  assign wr_cyc    = reg_we_i & (reg_addr_i == A_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      en_q      <= '0;
      cyc_en_q  <= 1'b0;
      ovf_q     <= '0;
      cyc_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_en_q <= reg_wdata_i[0];
      if (wr_en_set) begin
        en_q     <= en_q | reg_wdata_i[NUM_CNT-1:0];
        cyc_en_q <= cyc_en_q | reg_wdata_i[CYC_IDX];
      end else if (wr_en_clr) begin
        en_q     <= en_q & ~reg_wdata_i[NUM_CNT-1:0];
        cyc_en_q <= cyc_en_q & ~reg_wdata_i[CYC_IDX];
      end
      // set beats same-cycle clear
      ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata_i[NUM_CNT-1:0] : '0)) | ovf_set;
      if (wr_cyc) cyc_q <= reg_wdata_i[CNT_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] CNT_ADDR = A_CNT_BASE + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] EVT_ADDR = A_EVT_BASE + ADDR_W'(i);
    logic wr_cnt, wr_evt;
    assign wr_cnt = reg_we_i & (reg_addr_i == CNT_ADDR);
    assign wr_evt = reg_we_i & (reg_addr_i == EVT_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[i] <= '0;
        evt_q[i] <= '0;
      end else begin
        cnt_q[i] <= wr_cnt ? reg_wdata_i[CNT_W-1:0] : cnt_nxt[i];
        if (wr_evt) evt_q[i] <= reg_wdata_i[EVT_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL) begin
      reg_rdata_o[0] = ctrl_en_q;
    end else if (reg_addr_i == A_EN_SET || reg_addr_i == A_EN_CLR) begin
      reg_rdata_o[NUM_CNT-1:0] = en_q;
      reg_rdata_o[CYC_IDX]     = cyc_en_q;
    end else if (reg_addr_i == A_OVF) begin
      reg_rdata_o[NUM_CNT-1:0] = ovf_q;
    end else if (reg_addr_i == A_CYC) begin
      reg_rdata_o = DATA_W'(cyc_q);
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (reg_addr_i == A_CNT_BASE + ADDR_W'(i)) reg_rdata_o = DATA_W'(cnt_q[i]);
        if (reg_addr_i == A_EVT_BASE + ADDR_W'(i)) reg_rdata_o = DATA_W'(evt_q[i]);
      end
    end
  end
endmodule

// File: rtl/swinc_bank_chk.sv
module swinc_bank_chk #(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     swinc_we_i,
  input logic [31:0]              swinc_mask_i,
  input logic                     reg_we_i,
  input logic                     ctrl_en_i,
  input logic [NUM_CNT*CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0]         cyc_i,
  input logic [NUM_CNT-1:0]       ovf_i,
  input logic [NUM_CNT-1:0]       chain_i
);
  p_off_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swinc_we_i && !ctrl_en_i && !reg_we_i) |=> ($stable(cnt_i) && $stable(ovf_i)));

  p_zero_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swinc_we_i && swinc_mask_i == '0 && !reg_we_i) |=> ($stable(cnt_i) && $stable(ovf_i)));

  p_cycle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(cyc_i));

  p_ovf_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ((ovf_i & $past(ovf_i)) == $past(ovf_i)));

  p_idle_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !swinc_we_i) |=> ($stable(cnt_i) && $stable(ovf_i)));

  for (genvar p = 0; p < NUM_CNT / 2; p++) begin : g_pair_chk
    p_chain_lo_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_i[2*p] |=> !$rose(ovf_i[2*p]));
  end
endmodule

bind swinc_counter_bank swinc_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .swinc_we_i   (swinc_we_i),
  .swinc_mask_i (swinc_mask_i),
  .reg_we_i     (reg_we_i),
  .ctrl_en_i    (ctrl_en_q),
  .cnt_i        (cnt_flat),
  .cyc_i        (cyc_q),
  .ovf_i        (ovf_q),
  .chain_i      (chain)
);

// File: tb/swinc_counter_bank_test.sv
module swinc_counter_bank_test;
  localparam int N = 6;
  localparam logic [31:0] SWINC = 32'h000;
  localparam logic [31:0] CHAIN = 32'h01E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [31:0] sw_mask = '0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_run = 0;
  int n_fail = 0;

  // bench model
  logic [31:0] m_cnt [N];
  logic [31:0] m_evt [N];
  logic [N-1:0] m_en;
  logic        m_cyc_en;
  logic        m_ctrl;
  logic [N-1:0] m_ovf;
  logic [31:0] m_cyc;

  always #4ns clk = ~clk;

  swinc_counter_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .swinc_we_i(sw_we), .swinc_mask_i(sw_mask),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1ns;
    d = reg_rdata;
  endtask

  task automatic model_step(input logic we, input logic [6:0] a, input logic [31:0] d,
                            input logic sw, input logic [31:0] m);
    logic [N-1:0] set;
    set = '0;
    if (sw && m_ctrl) begin
      for (int p = 0; p < N/2; p++) begin
        logic ch, hl, hh;
        ch = (m_evt[2*p+1][9:0] == CHAIN[9:0]);
        hl = m[2*p]   && m_en[2*p]   && (m_evt[2*p][9:0] == SWINC[9:0]);
        hh = m[2*p+1] && m_en[2*p+1] && (m_evt[2*p+1][9:0] == SWINC[9:0]);
        if (hl) begin
          m_cnt[2*p] = m_cnt[2*p] + 1;
          if (m_cnt[2*p] == 0) begin
            if (ch) begin
              m_cnt[2*p+1] = m_cnt[2*p+1] + 1;
              if (m_cnt[2*p+1] == 0) set[2*p+1] = 1'b1;
            end else set[2*p] = 1'b1;
          end
        end
        if (!ch && hh) begin
          m_cnt[2*p+1] = m_cnt[2*p+1] + 1;
          if (m_cnt[2*p+1] == 0) set[2*p+1] = 1'b1;
        end
      end
    end
    if (we) begin
      if (a == 7'h00) m_ctrl = d[0];
      if (a == 7'h01) begin m_en = m_en | d[N-1:0]; m_cyc_en = m_cyc_en | d[31]; end
      if (a == 7'h02) begin m_en = m_en & ~d[N-1:0]; m_cyc_en = m_cyc_en & ~d[31]; end
      if (a == 7'h03) m_ovf = m_ovf & ~d[N-1:0];
      if (a == 7'h3F) m_cyc = d;
      for (int i = 0; i < N; i++) begin
        if (a == 7'h20 + 7'(i)) m_cnt[i] = d;
        if (a == 7'h40 + 7'(i)) m_evt[i] = {22'd0, d[9:0]};
      end
    end
    m_ovf = m_ovf | set;
  endtask

  task automatic cyc(input logic we, input logic [6:0] a, input logic [31:0] d,
                     input logic sw, input logic [31:0] m);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; sw_we = sw; sw_mask = m;
    @(negedge clk);
    reg_we = 1'b0; sw_we = 1'b0; sw_mask = '0;
    model_step(we, a, d, sw, m);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic inc(input logic [31:0] m);
    cyc(1'b0, 7'h00, '0, 1'b1, m);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin
      rd(7'h20 + 7'(i), v);
      chk($sformatf("R6 %s cnt%0d", tag, i), v, m_cnt[i]);
    end
    rd(7'h03, v);
    chk($sformatf("R7 %s ovf", tag), v, {26'd0, m_ovf});
    rd(7'h3F, v);
    chk($sformatf("R5 %s cyc", tag), v, m_cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] en_pat [4];
    en_pat[0] = 32'h8000003F; en_pat[1] = 32'h80000015;
    en_pat[2] = 32'h8000002B; en_pat[3] = 32'h8000003F;
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_evt[i] = '0; end
    m_en = '0; m_cyc_en = 1'b0; m_ctrl = 1'b0; m_ovf = '0; m_cyc = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(7'h00, v); chk("R12 ctrl reset", v, 32'h0);
    rd(7'h01, v); chk("R12 enable reset", v, 32'h0);
    rd(7'h03, v); chk("R12 ovf reset", v, 32'h0);
    rd(7'h3F, v); chk("R12 cyc reset", v, 32'h0);
    for (int i = 0; i < N; i++) begin
      rd(7'h20 + 7'(i), v); chk("R12 cnt reset", v, 32'h0);
      rd(7'h40 + 7'(i), v); chk("R12 evt reset", v, 32'h0);
    end

    // R12 readback
    wr(7'h00, 32'h1);   rd(7'h00, v); chk("R12 ctrl rb", v, 32'h1);
    wr(7'h01, 32'hFFFFFFFF); rd(7'h02, v); chk("R3 enable set rb", v, 32'h8000003F);
    wr(7'h02, 32'h80000005); rd(7'h01, v); chk("R3 enable clr rb", v, 32'h0000003A);
    wr(7'h44, 32'hFFFF_F3A5); rd(7'h44, v); chk("R12 evt rb", v, 32'h3A5);
    wr(7'h44, 32'h0);

    // sweeps over configurations and all 64 low masks
    for (int cfg = 0; cfg < 4; cfg++) begin
      wr(7'h00, {31'd0, cfg != 3});
      wr(7'h02, 32'hFFFFFFFF);
      wr(7'h01, en_pat[cfg]);
      wr(7'h03, 32'hFFFFFFFF);
      for (int i = 0; i < N; i++) begin
        logic [31:0] e;
        e = SWINC;
        if (cfg == 1 && (i == 1 || i == 3)) e = CHAIN;
        if (cfg == 2 && i == 2) e = 32'h11;
        if (cfg == 2 && i == 5) e = 32'h08;
        wr(7'h40 + 7'(i), e);
        wr(7'h20 + 7'(i), 32'hFFFFFFE0 + 32'(i * 3));
      end
      if (cfg == 1) begin wr(7'h21, 32'hFFFFFFFF); wr(7'h23, 32'h7); end
      wr(7'h3F, 32'h12340000 + 32'(cfg));
      for (int m = 0; m < 64; m++) begin
        inc(32'h80000000 | 32'(m) | (32'(m) << 10));
        check_all($sformatf("cfg%0d m%0d", cfg, m));
      end
    end

    // R1: run bit clear
    wr(7'h00, 32'h0); wr(7'h02, 32'hFFFFFFFF); wr(7'h01, 32'h8000003F);
    wr(7'h03, 32'hFFFFFFFF);
    for (int i = 0; i < N; i++) begin wr(7'h40 + 7'(i), 32'h0); wr(7'h20 + 7'(i), 32'hFFFFFFFF); end
    inc(32'hFFFFFFFF);
    rd(7'h20, v); chk("R1 run off cnt0", v, 32'hFFFFFFFF);
    rd(7'h03, v); chk("R1 run off ovf", v, 32'h0);
    wr(7'h00, 32'h1);

    // R2: empty mask
    inc(32'h0);
    rd(7'h25, v); chk("R2 zero mask cnt5", v, 32'hFFFFFFFF);
    rd(7'h03, v); chk("R2 zero mask ovf", v, 32'h0);

    // R8 and R10: chained pair 0/1, high enable clear
    wr(7'h41, CHAIN); wr(7'h02, 32'h2); wr(7'h21, 32'h5);
    inc(32'h3);
    rd(7'h20, v); chk("R8 chain low wraps", v, 32'h0);
    rd(7'h21, v); chk("R10 carry with high disabled", v, 32'h6);
    rd(7'h03, v); chk("R8 no low ovf", v, 32'h0);

    // R9: carry wraps high half
    wr(7'h20, 32'hFFFFFFFF); wr(7'h21, 32'hFFFFFFFF);
    inc(32'h1);
    rd(7'h21, v); chk("R9 high wraps", v, 32'h0);
    rd(7'h03, v); chk("R9 high ovf bit", v, 32'h2);

    // R7: unchained wrap, R4: other event ignored
    wr(7'h42, 32'h0); wr(7'h43, 32'h11); wr(7'h23, 32'h9);
    inc(32'hC);
    rd(7'h22, v); chk("R6 unchained wraps", v, 32'h0);
    rd(7'h23, v); chk("R4 other event ignored", v, 32'h9);
    rd(7'h03, v); chk("R7 own ovf bit", v, 32'h6);

    // R11: W1C, sticky, set wins over clear
    wr(7'h03, 32'h2);
    rd(7'h03, v); chk("R11 w1c clears bit1", v, 32'h4);
    inc(32'h0); rd(7'h03, v); chk("R11 sticky", v, 32'h4);
    wr(7'h24, 32'hFFFFFFFF);
    cyc(1'b1, 7'h03, 32'h14, 1'b1, 32'h10);
    rd(7'h03, v); chk("R11 set beats clear", v, 32'h10);

    // R13: counter write beats same-cycle increment
    cyc(1'b1, 7'h24, 32'hABCD0000, 1'b1, 32'h10);
    rd(7'h24, v); chk("R13 write priority", v, 32'hABCD0000);
    inc(32'h10);
    rd(7'h24, v); chk("R13 next-cycle visible", v, 32'hABCD0001);

    // R5: cycle counter enabled and selected
    wr(7'h3F, 32'hFFFFFFFF);
    inc(32'h80000000);
    rd(7'h3F, v); chk("R5 cycle counter", v, 32'hFFFFFFFF);
    check_all("final");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule